// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Core

This block holds the per-vector state of a local interrupt controller for up to 256 vectors: which vectors are requested, which are being serviced, and whether each was raised as a level-triggered or edge-triggered source. Each vector falls into a 16-level priority class given by its upper four bits. A higher vector number means a higher priority.

The core combines the task priority and the highest in-service vector into a processor priority. It uses that value to decide whether the top request may interrupt the processor. On an acknowledge it hands out a vector, or the spurious vector when the top request is masked. On an end-of-interrupt it retires the highest in-service vector and, for level-triggered sources, sends out a broadcast so the originating source can re-arm.

The surrounding logic drives one-cycle strobes into the core. Routing, timers and legacy pass-through sit outside it.

Top module: `irq_accept_core`

## Requirements
- R1: After reset, the request, in-service and trigger-mode arrays are clear. The task priority is 0. The spurious-vector register holds vector 0xFF with the enable bit clear. `irq_pending_o`, `ack_valid_o` and `eoi_bcast_o` are low and `ppr_o` is 0.
- R2: A request strobe sets the vector's request bit. It sets the vector's trigger-mode bit when `req_level_i` is 1 and clears that bit when `req_level_i` is 0.
- R3: The top request is the highest-numbered vector with its request bit set.
- R4: Let T be task priority bits [7:4] and S be bits [7:4] of the highest in-service vector, with S = 0 when nothing is in service. If T >= S, `ppr_o` equals the full 8-bit task priority. Otherwise `ppr_o` equals S followed by four zero bits.
- R5: While the enable bit (bit 8 of the spurious-vector write) is clear, `irq_pending_o` stays low and an acknowledge returns nothing (`ack_valid_o` stays low).
- R6: The top request is blocked when `ppr_o` is nonzero and the top request's class is less than or equal to bits [7:4] of `ppr_o`. An acknowledge while the top request is blocked returns the spurious vector (bits [7:0] of the register) and changes no array.
- R7: An acknowledge with an unblocked request pulses `ack_valid_o` on the next cycle with the top request vector on `ack_vec_o`. It also clears that vector's request bit and sets its in-service bit.
- R8: An end-of-interrupt strobe clears the highest in-service bit. With no vector in service, it changes nothing.
- R9: An end-of-interrupt that retires vector V pulses `eoi_bcast_o` on the next cycle, with V on `eoi_vec_o`, only if V's trigger-mode bit is set and the directed-EOI bit (bit 12 of the spurious-vector write) is clear.
- R10: A spurious-vector write keeps bits [7:0] as the spurious vector, bit 8 as the enable and bit 12 as the directed-EOI control, and discards all other bits.
- R11: `irq_pending_o` is registered. It reflects the state one cycle after any change to the arrays, the task priority or the spurious-vector register.
- R12: When a request and an acknowledge fall in the same cycle, the acknowledge is decided on the state before that cycle. A request for the vector being acknowledged leaves its request bit set and updates its trigger-mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Vector request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_level_i | input | 1 | 1 = level-triggered request, 0 = edge-triggered request |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_i | input | 8 | Task priority value |
| svr_we_i | input | 1 | Spurious-vector register write strobe |
| svr_wdata_i | input | 16 | Spurious-vector write data |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_pending_o | output | 1 | Registered interrupt-pending line |
| ack_valid_o | output | 1 | Acknowledge response pulse |
| ack_vec_o | output | 8 | Acknowledged or spurious vector |
| ppr_o | output | 8 | Processor priority |
| eoi_bcast_o | output | 1 | End-of-interrupt broadcast pulse |
| eoi_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
A new request and an acknowledge can land in the same cycle. The most demanding case is a level-triggered request for the very vector being acknowledged. The bench provokes this by raising `req_valid_i` and `ack_i` on the same edge.

It then judges the outcome at the ports:
- the acknowledge must return the vector;
- pending must stay low while the vector is in service at the same class;
- the following end-of-interrupt must broadcast, which shows the simultaneous level request reached the trigger-mode array;
- after that end-of-interrupt, pending must rise again and a second acknowledge must return the same vector.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int SVR_W       = 16;
  localparam int SVR_EN_BIT  = 8;
  localparam int SVR_DEO_BIT = 12;

  typedef struct packed {
    logic       dir_eoi;
    logic       en;
    logic [7:0] vec;
  } svr_t;

  localparam svr_t SVR_RESET = '{dir_eoi: 1'b0, en: 1'b0, vec: 8'hFF};
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N      = 256,
  parameter int WORD_W = 32
) (
  input  logic [N-1:0]         bits_i,
  output logic                 valid_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int NW = N / WORD_W;
  localparam int BW = $clog2(WORD_W);
  localparam int WW = $clog2(NW);

  logic [NW-1:0] word_nz;
  logic [BW-1:0] word_hi [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [WORD_W-1:0] slice;
    logic [BW-1:0]     hi;
    assign slice = bits_i[w*WORD_W +: WORD_W];
    always_comb begin
      hi = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (slice[b]) hi = BW'(b);
      end
    end
    assign word_nz[w] = |slice;
    assign word_hi[w] = hi;
  end

  always_comb begin
    idx_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (word_nz[w]) idx_o = {WW'(w), word_hi[w]};
    end
  end

  assign valid_o = |word_nz;
endmodule

// File: rtl/irq_ppr_calc.sv
module irq_ppr_calc #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic [VEC_W-1:0] isr_vec_i,
  input  logic             isr_valid_i,
  output logic [VEC_W-1:0] ppr_o
);
  localparam int SUB_W = VEC_W - CLASS_W;

  logic [CLASS_W-1:0] tpr_cls, isr_cls;

  assign tpr_cls = tpr_i[VEC_W-1 -: CLASS_W];
  assign isr_cls = isr_valid_i ? isr_vec_i[VEC_W-1 -: CLASS_W] : '0;
  assign ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {SUB_W{1'b0}}};
endmodule

// File: rtl/irq_accept_core.sv
module irq_accept_core
  import irq_accept_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int CLASS_W = 4,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic             req_level_i,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             svr_we_i,
  input  logic [SVR_W-1:0] svr_wdata_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_pending_o,
  output logic             ack_valid_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic [VEC_W-1:0] ppr_o,
  output logic             eoi_bcast_o,
  output logic [VEC_W-1:0] eoi_vec_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  logic [VEC_W-1:0]   tpr_q;
  svr_t               svr_q;
  logic               pend_q, ack_v_q, bcast_q;
  logic [VEC_W-1:0]   ack_vec_q, eoi_vec_q;

  logic               irr_valid, isr_valid;
  logic [VEC_W-1:0]   irr_top, isr_top, ppr;
  logic               blocked, pend_now, ack_take, ack_spur, eoi_take;

  irq_prio_enc #(.N(NUM_VEC), .WORD_W(WORD_W)) u_irr_enc (
    .bits_i(irr_q), .valid_o(irr_valid), .idx_o(irr_top)
  );

  irq_prio_enc #(.N(NUM_VEC), .WORD_W(WORD_W)) u_isr_enc (
    .bits_i(isr_q), .valid_o(isr_valid), .idx_o(isr_top)
  );

  irq_ppr_calc #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_ppr (
    .tpr_i(tpr_q), .isr_vec_i(isr_top), .isr_valid_i(isr_valid), .ppr_o(ppr)
  );

  assign blocked  = (ppr != '0) &&
                    (irr_top[VEC_W-1 -: CLASS_W] <= ppr[VEC_W-1 -: CLASS_W]);
  assign pend_now = svr_q.en && irr_valid && !blocked;
  assign ack_take = ack_i && pend_now;
  assign ack_spur = ack_i && svr_q.en && irr_valid && blocked;
  assign eoi_take = eoi_i && isr_valid;

  // acknowledge clear first, then a same-cycle request re-sets the bit
  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_take) begin
      irr_d[irr_top] = 1'b0;
      isr_d[irr_top] = 1'b1;
    end
    if (eoi_take) isr_d[isr_top] = 1'b0;
    if (req_valid_i) begin
      irr_d[req_vec_i] = 1'b1;
      tmr_d[req_vec_i] = req_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q     <= '0;
      isr_q     <= '0;
      tmr_q     <= '0;
      tpr_q     <= '0;
      svr_q     <= SVR_RESET;
      pend_q    <= 1'b0;
      ack_v_q   <= 1'b0;
      ack_vec_q <= '0;
      bcast_q   <= 1'b0;
      eoi_vec_q <= '0;
    end else begin
      irr_q   <= irr_d;
      isr_q   <= isr_d;
      tmr_q   <= tmr_d;
      pend_q  <= pend_now;
      ack_v_q <= ack_take || ack_spur;
      if (ack_take)      ack_vec_q <= irr_top;
      else if (ack_spur) ack_vec_q <= svr_q.vec;
      bcast_q <= eoi_take && tmr_q[isr_top] && !svr_q.dir_eoi;
      if (eoi_take) eoi_vec_q <= isr_top;
      if (tpr_we_i) tpr_q <= tpr_i;
      if (svr_we_i) begin
        svr_q.vec     <= svr_wdata_i[7:0];
        svr_q.en      <= svr_wdata_i[SVR_EN_BIT];
        svr_q.dir_eoi <= svr_wdata_i[SVR_DEO_BIT];
      end
    end
  end

  assign irq_pending_o = pend_q;
  assign ack_valid_o   = ack_v_q;
  assign ack_vec_o     = ack_vec_q;
  assign ppr_o         = ppr;
  assign eoi_bcast_o   = bcast_q;
  assign eoi_vec_o     = eoi_vec_q;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int NUM_VEC = 256,
  parameter int CLASS_W = 4,
  parameter int VEC_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [VEC_W-1:0]   req_vec_i,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               irq_pending_o,
  input logic               ack_valid_o,
  input logic [VEC_W-1:0]   ppr_o,
  input logic               eoi_bcast_o,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [VEC_W-1:0]   tpr_q,
  input logic               svr_en,
  input logic               svr_deo
);
  assert_req_sets_irr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> irr_q[$past(req_vec_i)]);

  assert_ppr_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o[VEC_W-1 -: CLASS_W] >= tpr_q[VEC_W-1 -: CLASS_W]);

  assert_pend_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pending_o |-> $past(svr_en));

  assert_ack_resp_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(ack_i));

  assert_ack_eoi_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && eoi_i));

  assert_bcast_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bcast_o |-> ($past(eoi_i) && !$past(svr_deo)));
endmodule

bind irq_accept_core irq_accept_chk #(
  .NUM_VEC(NUM_VEC), .CLASS_W(CLASS_W), .VEC_W(VEC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_vec_i(req_vec_i),
  .ack_i(ack_i), .eoi_i(eoi_i), .irq_pending_o(irq_pending_o),
  .ack_valid_o(ack_valid_o), .ppr_o(ppr_o), .eoi_bcast_o(eoi_bcast_o),
  .irr_q(irr_q), .tpr_q(tpr_q), .svr_en(svr_q.en), .svr_deo(svr_q.dir_eoi)
);

// File: tb/tb_irq_accept_core.sv
module tb_irq_accept_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_level = 0, tpr_we = 0, svr_we = 0, ack = 0, eoi = 0;
  logic [7:0] req_vec = 0, tpr = 0;
  logic [15:0] svr_wdata = 0;
  logic pend, ack_valid, bcast;
  logic [7:0] ack_vec, ppr, eoi_vec;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_accept_core dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vec_i(req_vec),
    .req_level_i(req_level), .tpr_we_i(tpr_we), .tpr_i(tpr), .svr_we_i(svr_we),
    .svr_wdata_i(svr_wdata), .ack_i(ack), .eoi_i(eoi), .irq_pending_o(pend),
    .ack_valid_o(ack_valid), .ack_vec_o(ack_vec), .ppr_o(ppr),
    .eoi_bcast_o(bcast), .eoi_vec_o(eoi_vec)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(int v, bit lvl);
    @(negedge clk); req_valid = 1; req_vec = v[7:0]; req_level = lvl;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic do_eoi();
    @(negedge clk); eoi = 1;
    @(negedge clk); eoi = 0;
  endtask

  task automatic set_tpr(int v);
    @(negedge clk); tpr_we = 1; tpr = v[7:0];
    @(negedge clk); tpr_we = 0;
  endtask

  task automatic set_svr(int v);
    @(negedge clk); svr_we = 1; svr_wdata = v[15:0];
    @(negedge clk); svr_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(2);
    // R1 reset state
    chk("R1 pending", pend, 0);
    chk("R1 ppr", ppr, 0);
    chk("R1 ack_valid", ack_valid, 0);
    chk("R1 bcast", bcast, 0);
    rst_n = 1;
    idle(1);
    do_ack();
    chk("R1 ack after reset returns nothing", ack_valid, 0);

    // R5 disabled: request but no pending, ack returns nothing
    do_req(8'h40, 0);
    idle(2);
    chk("R5 pending while disabled", pend, 0);
    do_ack();
    chk("R5 ack while disabled", ack_valid, 0);
    // R11 enable: pending rises one cycle after the register changes
    @(negedge clk); svr_we = 1; svr_wdata = 16'h01FF;
    @(negedge clk); svr_we = 0;
    chk("R11 pending not yet", pend, 0);
    @(negedge clk);
    chk("R11 pending one cycle later", pend, 1);
    do_ack();
    chk("R7 ack valid 0x40", ack_valid, 1);
    chk("R7 ack vec 0x40", ack_vec, 8'h40);
    do_eoi();
    chk("R9 no bcast for edge", bcast, 0);

    // sweep of every vector: R2 R3 R4 R7 R8 R9
    for (int v = 0; v < 256; v++) begin
      do_req(v, v[0]);
      idle(1);
      chk("R11 sweep pending", pend, 1);
      do_ack();
      chk("R7 sweep ack valid", ack_valid, 1);
      chk("R3 sweep ack vec", ack_vec, v);
      chk("R4 sweep ppr isr class", ppr, (v >> 4) << 4);
      idle(1);
      chk("R7 sweep irr cleared", pend, 0);
      do_eoi();
      chk("R9 sweep bcast level only", bcast, v & 1);
      if (v & 1) chk("R9 sweep bcast vec", eoi_vec, v);
      chk("R8 sweep ppr after eoi", ppr, 0);
    end

    // R2 edge request clears a previous level mark
    do_req(8'h23, 1);
    do_req(8'h23, 0);
    do_ack();
    chk("R2 ack 0x23", ack_vec, 8'h23);
    do_eoi();
    chk("R2 tmr cleared no bcast", bcast, 0);

    // R3 R6 ordering and spurious fallback
    set_svr(16'h01AF);
    do_req(8'h35, 0); do_req(8'h92, 0); do_req(8'h71, 0);
    do_ack();
    chk("R3 highest first", ack_vec, 8'h92);
    do_ack();
    chk("R6 spurious valid", ack_valid, 1);
    chk("R6 spurious vec", ack_vec, 8'hAF);
    chk("R6 state unchanged ppr", ppr, 8'h90);
    do_eoi();
    do_ack();
    chk("R3 next 0x71", ack_vec, 8'h71);
    do_ack();
    chk("R6 0x35 blocked by 0x70", ack_vec, 8'hAF);
    do_eoi();
    do_ack();
    chk("R3 last 0x35", ack_vec, 8'h35);
    do_eoi();

    // R8 nested in-service: eoi retires the highest
    do_req(8'h40, 0); do_ack();
    do_req(8'hC0, 0); do_ack();
    chk("R8 nested ack", ack_vec, 8'hC0);
    chk("R4 nested ppr", ppr, 8'hC0);
    do_eoi();
    chk("R8 highest retired", ppr, 8'h40);
    do_eoi();
    chk("R8 second retired", ppr, 0);
    do_eoi();
    chk("R8 empty eoi no bcast", bcast, 0);
    chk("R8 empty eoi ppr", ppr, 0);

    // R4 R6 task priority
    set_tpr(8'h55);
    chk("R4 ppr equals tpr", ppr, 8'h55);
    do_req(8'h50, 0);
    idle(1);
    chk("R6 equal class blocked", pend, 0);
    do_ack();
    chk("R6 spurious under tpr", ack_vec, 8'hAF);
    do_req(8'h60, 0);
    idle(1);
    chk("R6 higher class pending", pend, 1);
    do_ack();
    chk("R3 ack 0x60", ack_vec, 8'h60);
    chk("R4 isr class wins", ppr, 8'h60);
    set_tpr(8'h6A);
    chk("R4 equal classes take full tpr", ppr, 8'h6A);
    set_tpr(8'h3F);
    chk("R4 lower tpr", ppr, 8'h60);
    do_eoi();
    set_tpr(0);
    idle(1);
    chk("R11 pending after tpr drop", pend, 1);
    do_ack();
    chk("R3 ack 0x50", ack_vec, 8'h50);
    do_eoi();

    // R10 R9 directed EOI bit and discarded bits
    set_svr(16'hF112 | 16'h0E00);
    do_req(8'h81, 1);
    do_ack();
    chk("R10 enable kept", ack_vec, 8'h81);
    do_eoi();
    chk("R9 directed eoi suppresses bcast", bcast, 0);
    chk("R8 directed eoi still retires", ppr, 0);
    do_req(8'h20, 0); do_ack();
    do_req(8'h25, 0); do_ack();
    chk("R10 spurious vec low byte", ack_vec, 8'h12);
    do_eoi(); do_ack();
    chk("R3 after eoi 0x25", ack_vec, 8'h25);
    do_eoi();
    set_svr(16'h01FF);

    // R12 request and acknowledge in the same cycle
    do_req(8'h77, 0);
    @(negedge clk); ack = 1; req_valid = 1; req_vec = 8'h77; req_level = 1;
    @(negedge clk); ack = 0; req_valid = 0;
    chk("R12 ack returns 0x77", ack_vec, 8'h77);
    idle(1);
    chk("R12 blocked by own class", pend, 0);
    do_eoi();
    chk("R12 level mark reached tmr", bcast, 1);
    chk("R12 bcast vec", eoi_vec, 8'h77);
    idle(1);
    chk("R12 request kept", pend, 1);
    do_ack();
    chk("R12 second ack", ack_vec, 8'h77);
    do_eoi();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule